// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Digital Core

This block is the device-side digital logic of a multi-channel converter that samples all of its channels at the same instant. A host writes a small configuration word over the parallel bus, raises a start strobe to freeze the channels and begin a conversion, watches a busy flag, and then pulls one result per channel off the bus with a train of read strobes. The analog side is replaced by a sample generator that yields a known value for every channel and conversion after a fixed number of clock cycles, so the block can be built and checked on its own.

All strobes are active-low except the start strobe, and all are sampled on the core clock. A configuration write takes effect when the write strobe rises after a low period that had chip select low. Conversion starts on a rising start strobe, and a rising edge that comes while a conversion is still running is ignored. Results are stored in offset binary and converted on the way out when two's complement output is selected. Reads walk a channel pointer that goes back to channel 0 whenever a conversion completes.

Top module: `sadc_core`

## Requirements
- R1: A configuration write stores `din[3:0]` when `wr_n` rises after a cycle in which `cs_n` and `wr_n` were both low; a write strobe with `cs_n` high changes nothing. After reset the configuration is all zero.
- R2: `ref_ext` follows configuration bit 3 (1 selects the external reference).
- R3: Configuration bit 2 set gives two's complement output, which is the stored offset-binary result with its MSB inverted; bit 2 clear gives the offset-binary value unchanged.
- R4: Configuration bit 1 is reserved and setting it has no effect on any output.
- R5: With configuration bit 0 clear, `acq` is high exactly when no conversion is running and `convst` is low.
- R6: With configuration bit 0 set, `acq` is high exactly when no conversion is running, whatever the level of `convst`.
- R7: A rising edge of `convst` seen while idle starts a conversion: `eoc` is high from the next cycle for exactly `CONV_LAT` cycles and then low.
- R8: A rising edge of `convst` while a conversion is running is ignored and does not stretch or restart it.
- R9: `dout_en` is high only while both `cs_n` and `rd_n` are low; otherwise the bus is released.
- R10: Each read period (the cycle after `cs_n` low and `rd_n` low stops holding) moves to the next channel; after channel `NUM_CH-1` it wraps to channel 0, whether `cs_n` stays low or toggles.
- R11: Completion of a conversion sets the channel pointer back to channel 0.
- R12: Conversion number k (k counted from 0 after reset) yields for channel c the offset-binary value ((k*0x1357 + c*0x0F0F) mod 2^16) XOR 0xA5A5; before the first conversion every result reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Configuration write strobe, active low |
| rd_n | input | 1 | Result read strobe, active low |
| convst | input | 1 | Conversion start, rising edge starts |
| din | input | 16 | Bus data from host (bits 3..0 used for configuration) |
| dout | output | 16 | Result for the current channel |
| dout_en | output | 1 | Drive enable for the bus; low means high impedance |
| eoc | output | 1 | High while a conversion runs |
| acq | output | 1 | High while the channels are tracking |
| ref_ext | output | 1 | External reference selected |

## Verification
The bench builds the core with four channels and a conversion latency of five cycles, so that a read burst of six strobes crosses the wrap from the last channel back to channel 0, and a second start edge can land in the middle of a running conversion within a few cycles. The short latency also lets a partial readout be interrupted by a fresh conversion, which reaches the pointer reset. Both acquisition modes and both output formats are exercised against a behavioural model that is compared on every clock.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  localparam int SMP_W = 16;

  typedef struct packed {
    logic ref_ext;
    logic fmt_twos;
    logic rsvd;
    logic auto_acq;
  } sadc_cfg_t;

  // Stand-in for the converter array: a deterministic code per conversion and channel
  function automatic logic [SMP_W-1:0] stub_sample(input logic [15:0] conv_no,
                                                   input logic [7:0]  chan);
    logic [15:0] mix;
    mix = conv_no * 16'h1357 + {8'h00, chan} * 16'h0F0F;
    return SMP_W'(mix ^ 16'hA5A5);
  endfunction

  // Offset binary to two's complement is an MSB flip
  function automatic logic [SMP_W-1:0] apply_format(input logic [SMP_W-1:0] raw,
                                                    input logic twos);
    return twos ? {~raw[SMP_W-1], raw[SMP_W-2:0]} : raw;
  endfunction

endpackage

// File: rtl/sadc_cfg_reg.sv
module sadc_cfg_reg
  import sadc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       wr_n,
  input  logic [3:0] wr_data,
  output sadc_cfg_t  cfg
);

  logic       wr_open_q;
  logic [3:0] shadow_q;
  sadc_cfg_t  cfg_q;

  wire wr_open   = !cs_n && !wr_n;
  wire wr_commit = wr_open_q && wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_open_q <= 1'b0;
      shadow_q  <= '0;
      cfg_q     <= '0;
    end else begin
      wr_open_q <= wr_open;
      if (wr_open) shadow_q <= wr_data;
      if (wr_commit) cfg_q <= sadc_cfg_t'(shadow_q);
    end
  end

  assign cfg = cfg_q;

  // R1: reset leaves the configuration at zero
  p_cfg_reset_r1: assert property (@(posedge clk) rst |=> cfg_q == '0);
  // R1: no rising write strobe after an open write, no change
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !(wr_open_q && wr_n) |=> $stable(cfg_q));

endmodule

// File: rtl/sadc_conv_ctrl.sv
module sadc_conv_ctrl #(
  parameter int CONV_LAT = 20,
  parameter int IDX_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             convst,
  input  logic             auto_acq,
  output logic             busy,
  output logic             done,
  output logic             acq,
  output logic [IDX_W-1:0] conv_idx
);

  localparam int CNT_W = (CONV_LAT > 2) ? $clog2(CONV_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_LAT - 1);

  logic             convst_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  wire start_edge = convst && !convst_q;
  wire start      = start_edge && !busy_q;
  wire finish     = busy_q && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      convst_q <= 1'b1;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
    end else begin
      convst_q <= convst;
      if (busy_q) begin
        if (finish) begin
          busy_q <= 1'b0;
          idx_q  <= idx_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  always_comb begin
    if (busy_q)        acq = 1'b0;
    else if (auto_acq) acq = 1'b1;
    else               acq = !convst;
  end

  assign busy     = busy_q;
  assign done     = finish;
  assign conv_idx = idx_q;

  // R7: a conversion starts its count at zero
  p_start_count_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> cnt_q == '0);
  // R8: a running conversion keeps counting up regardless of convst
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != CNT_LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  // R7: completion is a single-cycle event followed by idle
  p_done_once_r7: assert property (@(posedge clk) disable iff (rst)
    finish |=> (!busy_q && !finish));
  // R6: never tracking while converting
  p_acq_excl_r6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !acq);

endmodule

// File: rtl/sadc_readout.sv
module sadc_readout
  import sadc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             conv_done,
  input  logic [IDX_W-1:0] conv_idx,
  input  logic             fmt_twos,
  output logic [SMP_W-1:0] dout,
  output logic             dout_en
);

  localparam int PTR_W = (NUM_CH > 2) ? $clog2(NUM_CH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_CH - 1);

  logic [SMP_W-1:0] result_q [NUM_CH];
  logic [PTR_W-1:0] ptr_q;
  logic             rd_open_q;

  wire rd_open = !cs_n && !rd_n;
  wire rd_end  = rd_open_q && !rd_open;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) result_q[ch] <= '0;
      else if (conv_done) result_q[ch] <= stub_sample(16'(conv_idx), 8'(ch));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      rd_open_q <= 1'b0;
    end else begin
      rd_open_q <= rd_open;
      if (conv_done)   ptr_q <= '0;
      else if (rd_end) ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign dout_en = rd_open;
  assign dout    = apply_format(result_q[ptr_q], fmt_twos);

  // R11: completion brings the pointer to channel 0
  p_ptr_reset_r11: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> ptr_q == '0);
  // R10: the pointer only moves when a read period closes or a conversion ends
  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(rd_end || conv_done) |=> $stable(ptr_q));
  // R10: the pointer stays within the channel range
  p_ptr_range_r10: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= PTR_LAST);

endmodule

// File: rtl/sadc_core.sv
module sadc_core
  import sadc_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int CONV_LAT = 20,
  parameter int IDX_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             convst,
  input  logic [SMP_W-1:0] din,
  output logic [SMP_W-1:0] dout,
  output logic             dout_en,
  output logic             eoc,
  output logic             acq,
  output logic             ref_ext
);

  sadc_cfg_t        cfg;
  logic             conv_busy;
  logic             conv_done;
  logic [IDX_W-1:0] conv_idx;

  sadc_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .wr_data (din[3:0]),
    .cfg     (cfg)
  );

  sadc_conv_ctrl #(
    .CONV_LAT (CONV_LAT),
    .IDX_W    (IDX_W)
  ) u_conv (
    .clk      (clk),
    .rst      (rst),
    .convst   (convst),
    .auto_acq (cfg.auto_acq),
    .busy     (conv_busy),
    .done     (conv_done),
    .acq      (acq),
    .conv_idx (conv_idx)
  );

  sadc_readout #(
    .NUM_CH (NUM_CH),
    .IDX_W  (IDX_W)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .conv_done (conv_done),
    .conv_idx  (conv_idx),
    .fmt_twos  (cfg.fmt_twos),
    .dout      (dout),
    .dout_en   (dout_en)
  );

  assign eoc     = conv_busy;
  assign ref_ext = cfg.ref_ext;

  // R9: the bus is never driven while chip select is high
  p_bus_release_r9: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !dout_en);

endmodule

// File: tb/sadc_core_tb.sv
module sadc_core_tb_top;

  localparam int NCH = 4;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, convst = 1'b1;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        dout_en, eoc, acq, ref_ext;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sadc_core #(.NUM_CH(NCH), .CONV_LAT(LAT), .IDX_W(16)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .convst(convst), .din(din), .dout(dout), .dout_en(dout_en),
    .eoc(eoc), .acq(acq), .ref_ext(ref_ext)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cfg, m_shadow, m_conv_no, m_left, m_ptr, m_eoc_len;
  bit m_wr_prev, m_rd_prev, m_cv_prev, m_busy;
  int m_res[NCH];

  function automatic int sample_of(int k, int c);
    return ((k * 4951 + c * 3855) % 65536) ^ 42405;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      if (rst) begin
        m_cfg = 0; m_shadow = 0; m_conv_no = 0; m_left = 0; m_ptr = 0;
        m_wr_prev = 0; m_rd_prev = 0; m_cv_prev = 1; m_busy = 0; m_eoc_len = 0;
        foreach (m_res[i]) m_res[i] = 0;
      end else begin
        bit wr_now, rd_now, fin;
        wr_now = !cs_n && !wr_n;
        rd_now = !cs_n && !rd_n;
        fin = 0;
        if (m_wr_prev && wr_n) m_cfg = m_shadow;
        if (wr_now) m_shadow = int'(din[3:0]);
        m_wr_prev = wr_now;
        if (m_busy) begin
          m_left--;
          if (m_left == 0) begin
            m_busy = 0; fin = 1;
            for (int c = 0; c < NCH; c++) m_res[c] = sample_of(m_conv_no, c);
            m_conv_no++;
          end
        end else if (convst && !m_cv_prev) begin
          m_busy = 1; m_left = LAT;
        end
        m_cv_prev = convst;
        if (fin) m_ptr = 0;
        else if (m_rd_prev && !rd_now) m_ptr = (m_ptr + 1) % NCH;
        m_rd_prev = rd_now;
      end
      #1;
      begin
        int exp_d;
        bit exp_acq;
        exp_d = m_res[m_ptr];
        if (m_cfg & 4) exp_d = exp_d ^ 32768;
        exp_acq = m_busy ? 1'b0 : ((m_cfg & 1) ? 1'b1 : !convst);
        chk(eoc == m_busy, "R7 eoc", int'(eoc), int'(m_busy));
        if (m_cfg & 1) chk(acq == exp_acq, "R6 acq", int'(acq), int'(exp_acq));
        else           chk(acq == exp_acq, "R5 acq", int'(acq), int'(exp_acq));
        chk(dout_en == (!cs_n && !rd_n), "R9 dout_en", int'(dout_en), int'(!cs_n && !rd_n));
        chk(ref_ext == ((m_cfg >> 3) & 1), "R2 ref_ext", int'(ref_ext), (m_cfg >> 3) & 1);
        if (dout_en)
          chk(int'(dout) == exp_d, "R3 R10 R11 R12 dout", int'(dout), exp_d);
        if (!rst) begin
          if (eoc) m_eoc_len++;
          else if (m_eoc_len != 0) begin
            chk(m_eoc_len == LAT, "R7 R8 eoc length", m_eoc_len, LAT);
            m_eoc_len = 0;
          end
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [3:0] v, input bit sel);
    @(negedge clk); cs_n = !sel; wr_n = 1'b0; din = {12'h0, v};
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1; din = '0;
    idle(1);
  endtask

  task automatic rd_burst(input int n, input bit hold_cs);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
      idle(1);
      @(negedge clk); rd_n = 1'b1; if (!hold_cs) cs_n = 1'b1;
    end
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic cv_pulse(input int low_cycles);
    @(negedge clk); convst = 1'b0;
    idle(low_cycles);
    @(negedge clk); convst = 1'b1;
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    chk(eoc == 1'b0, "R7 reset eoc", int'(eoc), 0);
    chk(ref_ext == 1'b0, "R1 reset config", int'(ref_ext), 0);
    chk(dout_en == 1'b0, "R9 reset bus", int'(dout_en), 0);
    rd_burst(2, 1'b1);                          // R12: zeros before any conversion
    cv_pulse(3);                                // R5: tracking while convst low
    idle(2);
    cv_pulse(0);                                // R8: edge during conversion
    idle(LAT + 3);
    rd_burst(6, 1'b1);                          // R10: wrap with CS held low
    rd_burst(3, 1'b0);                          // R10: CS toggled
    wr_cfg(4'b0100, 1'b1);                      // R3: two's complement
    rd_burst(2, 1'b1);
    wr_cfg(4'b1000, 1'b0);                      // R1: CS high, ignored
    chk(ref_ext == 1'b0, "R1 write without CS", int'(ref_ext), 0);
    wr_cfg(4'b1001, 1'b1);                      // R2, R6
    chk(ref_ext == 1'b1, "R1 R2 committed write", int'(ref_ext), 1);
    idle(2);
    chk(acq == 1'b1, "R6 idle tracking", int'(acq), 1);
    cv_pulse(0);
    idle(LAT + 2);
    rd_burst(5, 1'b1);
    wr_cfg(4'b1011, 1'b1);                      // R4: reserved bit set
    chk(acq == 1'b1, "R4 reserved bit acq", int'(acq), 1);
    rd_burst(2, 1'b1);
    cv_pulse(1);                                // R11: new result resets pointer
    idle(LAT + 2);
    rd_burst(1, 1'b1);
    idle(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule